// File: doc/BRIEF.md
# Index-XOR Permute and Carry-less Multiply Unit

This block computes one of two bit-level functions of a pair of 32-bit operands. In permute mode it moves every bit of operand A to a new position: the new index is the old index XORed with a 5-bit control value taken from operand B. Each control bit swaps neighbouring blocks whose size is that bit's power of two.

In multiply mode it ANDs every bit of A with every bit of B. It then XOR-reduces the products into result bit k, taking every pair whose indices XOR to k. This is a carry-less product in which the index XOR stands where a carry-less multiply would add the indices. The same value comes from XOR-accumulating the permute of A by k for every set bit k of B.

The function is combinational. One register stage holds the result and raises a valid flag one clock after the request. A parameter selects between two equivalent multiply networks.

Top module: `gxm_unit`

## Requirements
- R1: While rst_n is low and at the first clock after it, out_valid is 0 and result is 0.
- R2: out_valid is high in exactly the cycle after a clock edge at which in_valid was high, and low otherwise.
- R3: With mode = 0 (permute), result bit i equals op_a bit (i XOR s), where s is op_b[4:0].
- R4: In permute mode, op_b bits 31 down to 5 have no effect on result.
- R5: With mode = 1 (multiply), result bit k equals the XOR, over all index pairs (i, j) with i XOR j = k, of op_a[i] AND op_b[j].
- R6: In multiply mode, op_b = 1 << k gives the permute of op_a by k, op_b = 1 gives op_a, and op_b = 0 gives 0.
- R7: In multiply mode, swapping op_a and op_b does not change result.
- R8: In multiply mode with op_a equal to op_b, result bit 0 is the parity of op_a and all other bits are 0. An odd-parity value therefore multiplied by itself gives 1.
- R9: result changes only at a clock edge where in_valid is high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 1 | 0 = index-XOR permute, 1 = index-XOR carry-less multiply |
| op_a | input | 32 | Data operand |
| op_b | input | 32 | Control operand (permute) or second factor (multiply) |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Registered result |

## Verification
The permute mode is swept over all 32 control values with several data patterns: a walking one, an alternating pattern, all-ones and random words. This separates a wrong stage mask or a swapped stage order from a correct butterfly. Random upper control bits show that only the low five bits steer the network.

The multiply mode is driven with B set to zero, one and every single bit, which pins it to the permute. Squares of odd- and even-parity values expose grouping by index sum instead of index XOR. Random pairs are also applied in both operand orders and compared against a pairwise reference loop.

// File: rtl/gxm_pkg.sv
// Shared definitions for the index-XOR permute / multiply unit.
// Assumes operand widths are a power of two no larger than 64.
package gxm_pkg;

    // Operation select encoding carried on the mode pin.
    typedef enum logic {
        MODE_PERM = 1'b0,
        MODE_XMUL = 1'b1
    } op_mode_e;

    // Mask of the bit positions whose index has bit s clear (lower block of each pair).
    function automatic logic [63:0] lo_block_mask(int unsigned s);
        logic [63:0] m;
        for (int i = 0; i < 64; i++) begin
            m[i] = (((i >> s) & 1) == 0);
        end
        return m;
    endfunction

    // Even/odd parity of a word, used by the self-product property.
    function automatic logic word_parity(logic [63:0] w);
        return ^w;
    endfunction

endpackage

// File: rtl/gxm_butterfly.sv
// Index-XOR butterfly: output bit i = input bit (i XOR ctrl).
// One stage per control bit; stage s swaps neighbouring blocks of 2**s bits.
// Assumes DATA_W is a power of two, at most 64. Purely combinational.
module gxm_butterfly #(
    parameter int DATA_W = 32,
    localparam int CTRL_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [DATA_W-1:0] data_out
);
    import gxm_pkg::*;

    logic [DATA_W-1:0] stage_w [0:CTRL_W];

    assign stage_w[0] = data_in;

    for (genvar s = 0; s < CTRL_W; s++) begin : g_stage
        localparam logic [63:0] LO_FULL = lo_block_mask(s);
        localparam logic [DATA_W-1:0] LO = LO_FULL[DATA_W-1:0];
        localparam int DIST = 1 << s;
        logic [DATA_W-1:0] swapped_w;

        // Exchange each lower block with the upper block beside it.
        always_comb begin
            swapped_w = ((stage_w[s] & LO) << DIST) | ((stage_w[s] & ~LO) >> DIST);
        end

        // Apply the swap only when this control bit is set.
        assign stage_w[s+1] = ctrl[s] ? swapped_w : stage_w[s];
    end

    assign data_out = stage_w[CTRL_W];

endmodule

// File: rtl/gxm_xmul.sv
// Index-XOR carry-less multiply: bit k = XOR of a[i] & b[j] over i ^ j == k.
// IMPL = 0: direct AND/XOR grouping by index XOR.
// IMPL = 1: XOR-accumulate a butterfly copy of a per set bit of b.
// Both variants give identical results. Combinational.
module gxm_xmul #(
    parameter int DATA_W = 32,
    parameter int IMPL   = 0,
    localparam int CTRL_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] prod_out
);

    if (IMPL == 0) begin : g_direct
        for (genvar k = 0; k < DATA_W; k++) begin : g_bit
            logic acc;
            // Reduce every partial product whose index XOR equals k.
            always_comb begin
                acc = 1'b0;
                for (int i = 0; i < DATA_W; i++) begin
                    acc = acc ^ (a_in[i] & b_in[i ^ k]);
                end
            end
            assign prod_out[k] = acc;
        end
    end else begin : g_accum
        logic [DATA_W-1:0] perm_w [DATA_W];
        logic [DATA_W-1:0] acc;

        for (genvar k = 0; k < DATA_W; k++) begin : g_perm
            gxm_butterfly #(.DATA_W(DATA_W)) u_bfly (
                .data_in  (a_in),
                .ctrl     (CTRL_W'(k)),
                .data_out (perm_w[k])
            );
        end

        // Sum, in GF(2), the permuted copies selected by b.
        always_comb begin
            acc = '0;
            for (int k = 0; k < DATA_W; k++) begin
                if (b_in[k]) acc = acc ^ perm_w[k];
            end
        end
        assign prod_out = acc;
    end

endmodule

// File: rtl/gxm_unit.sv
// Top of the index-XOR permute / carry-less multiply unit.
// Selects permute (mode 0) or multiply (mode 1) and registers the result one
// cycle after in_valid with out_valid alongside. Result holds between requests.
// Synchronous active-low reset clears both outputs.
module gxm_unit #(
    parameter int DATA_W    = 32,
    parameter int XMUL_IMPL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    import gxm_pkg::*;

    localparam int CTRL_W = $clog2(DATA_W);

    logic [DATA_W-1:0] perm_w;
    logic [DATA_W-1:0] xmul_w;
    logic [DATA_W-1:0] next_w;

    gxm_butterfly #(.DATA_W(DATA_W)) u_perm (
        .data_in  (op_a),
        .ctrl     (op_b[CTRL_W-1:0]),
        .data_out (perm_w)
    );

    gxm_xmul #(.DATA_W(DATA_W), .IMPL(XMUL_IMPL)) u_xmul (
        .a_in     (op_a),
        .b_in     (op_b),
        .prod_out (xmul_w)
    );

    // Pick the function requested by mode.
    assign next_w = (mode == MODE_XMUL) ? xmul_w : perm_w;

    // Output register: capture on in_valid, flag validity for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_w;
        end
    end

endmodule

// File: rtl/gxm_unit_chk.sv
// Property checker for gxm_unit, attached by bind below.
module gxm_unit_chk #(
    parameter int DATA_W = 32,
    localparam int CTRL_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              mode,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);
    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R9
    AST_PERM_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode) |=> result[0] == $past(op_a[op_b[CTRL_W-1:0]])); // R3
    AST_PERM_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode) |=> $countones(result) == $countones($past(op_a))); // R3
    AST_XMUL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode && op_b == '0) |=> result == '0); // R6
    AST_XMUL_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode && op_b == DATA_W'(1)) |=> result == $past(op_a)); // R6
    AST_XMUL_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode && op_a == op_b) |=> result == {{(DATA_W-1){1'b0}}, $past(^op_a)}); // R8

endmodule

bind gxm_unit gxm_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/gxm_unit_tb.sv
`timescale 1ns/1ps
module gxm_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    gxm_unit #(.DATA_W(32), .XMUL_IMPL(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result)
    );

    // Reference permute: bit i takes a[i ^ s].
    function automatic logic [31:0] ref_perm(logic [31:0] a, logic [31:0] b);
        logic [31:0] r;
        int s = int'(b[4:0]);
        for (int i = 0; i < 32; i++) r[i] = a[i ^ s];
        return r;
    endfunction

    // Reference multiply: pairwise AND grouped by index XOR.
    function automatic logic [31:0] ref_xmul(logic [31:0] a, logic [31:0] b);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++)
            for (int j = 0; j < 32; j++)
                if (a[i] && b[j]) r[i ^ j] = ~r[i ^ j];
        return r;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // Issue one request and return the registered result one cycle later.
    task automatic run_op(logic m, logic [31:0] a, logic [31:0] b, output logic [31:0] r);
        @(negedge clk);
        mode = m; op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", {31'b0, out_valid}, 32'd1);
        r = result;
    endtask

    logic [31:0] pats [4];

    initial begin
        logic [31:0] r, r2, a, b, hold;
        pats[0] = 32'h0000_0001; pats[1] = 32'h5555_5555;
        pats[2] = 32'hFFFF_FFFF; pats[3] = 32'h1234_ABCD;

        repeat (3) @(negedge clk);
        check("R1", {31'b0, out_valid}, 32'd0);
        check("R1", result, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1", {31'b0, out_valid}, 32'd0);
        check("R1", result, 32'd0);

        // R3: every control value against fixed patterns.
        for (int p = 0; p < 4; p++)
            for (int s = 0; s < 32; s++) begin
                run_op(1'b0, pats[p], 32'(s), r);
                check("R3", r, ref_perm(pats[p], 32'(s)));
            end

        // R4: upper control bits must be ignored.
        for (int t = 0; t < 64; t++) begin
            a = $urandom; b = $urandom;
            run_op(1'b0, a, b, r);
            run_op(1'b0, a, {27'b0, b[4:0]}, r2);
            check("R4", r, r2);
            check("R4", r, ref_perm(a, b));
        end

        // R9 and R2: output holds and valid drops when idle.
        hold = result;
        @(negedge clk);
        check("R2", {31'b0, out_valid}, 32'd0);
        op_a = 32'hDEAD_BEEF; op_b = 32'h7; mode = 1'b1;
        @(negedge clk);
        check("R9", result, hold);

        // R6: zero, one and single-bit factors.
        for (int p = 0; p < 4; p++) begin
            run_op(1'b1, pats[p], 32'd0, r);
            check("R6", r, 32'd0);
            run_op(1'b1, pats[p], 32'd1, r);
            check("R6", r, pats[p]);
            for (int k = 0; k < 32; k++) begin
                run_op(1'b1, pats[p], 32'd1 << k, r);
                check("R6", r, ref_perm(pats[p], 32'(k)));
            end
        end

        // R8: self-products of odd- and even-parity values.
        run_op(1'b1, 32'h0000_0007, 32'h0000_0007, r); check("R8", r, 32'd1);
        run_op(1'b1, 32'h0000_0003, 32'h0000_0003, r); check("R8", r, 32'd0);
        run_op(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, r); check("R8", r, 32'd0);
        for (int t = 0; t < 32; t++) begin
            a = $urandom;
            run_op(1'b1, a, a, r);
            check("R8", r, {31'b0, ^a});
        end

        // R5 and R7: random pairs in both orders.
        for (int t = 0; t < 200; t++) begin
            a = $urandom; b = $urandom;
            if (t % 4 == 0) b = b & 32'h0000_00FF;
            run_op(1'b1, a, b, r);
            check("R5", r, ref_xmul(a, b));
            run_op(1'b1, b, a, r2);
            check("R7", r2, r);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule